// File: doc/BRIEF.md
# SPI Command Frame Decoder with CRC-Guarded Register Writes

This block is the receive side of a serial target that takes 32-bit command frames over an SPI Mode 1 link. Mode 1 means the clock idles low and the target samples its data input on the falling clock edge. The serial pins are brought into the system clock domain, and a frame is collected while chip select is held low. The frame is split into five fields: a target address, a one-way/round-trip mode flag, a register index, an 8-bit data byte and a 12-bit check field.

A 12-bit CRC is recomputed over the upper 20 bits of the frame as they arrive. When chip select returns high, the frame is acted on only if three conditions all hold:

- exactly 32 bits were clocked in;
- the recomputed CRC equals the check field;
- the target address equals this instance's address or the all-devices address.

An accepted frame writes its data byte into a small bank of 8-bit registers and latches its mode flag. A frame with a bad CRC raises a sticky error flag instead, and that flag stays set until a later frame arrives intact.

Top module: `spi_cmd_decoder`

## Requirements
- R1: While `rst` is high, and on the first clock after it, every register byte, `crc_error_o` and `one_way_o` read 0.
- R2: A frame is sampled MSB first on falling edges of `sclk` while `cs_n` is low. Its layout is: bits 31:27 target address, bit 26 mode flag, bits 25:20 register index, bits 19:12 data, bits 11:0 check field. An accepted frame stores its data byte in register `index`, which appears on `regs_o[8*index +: 8]`. No other byte changes.
- R3: The check field must equal a CRC computed over frame bits 31:12, MSB first, with a register that starts at zero and the polynomial x^12+x^10+x^9+x^7+x+1. A frame that fails this check changes no register and does not change `one_way_o`.
- R4: `crc_error_o` is set when a 32-bit frame fails the CRC check. It stays set across later frames that are discarded for length, and it is cleared by the next 32-bit frame whose CRC matches, whatever that frame's target address.
- R5: A frame with a correct CRC whose target address is neither `DEV_ADDR` (default 0x00) nor 0x1F changes no register and leaves `one_way_o` unchanged. Address 0x1F is accepted by every instance.
- R6: A frame that ends with other than exactly 32 falling `sclk` edges while `cs_n` was low is discarded. It changes no register, `one_way_o` or `crc_error_o`.
- R7: Every accepted frame copies its bit 26 to `one_way_o`, where 1 means one-way and 0 means round-trip.
- R8: An accepted frame whose register index is `NUM_REGS` (default 8) or more writes no register, but it still updates `one_way_o`.
- R9: Rising `sclk` edges, and any `sclk` activity while `cs_n` is high, sample nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, idles low |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data in, MSB first |
| regs_o | output | 8*NUM_REGS | Register bank contents; byte k is register k |
| crc_error_o | output | 1 | Sticky CRC mismatch flag |
| one_way_o | output | 1 | Mode flag from the last accepted frame |

## Verification
The assertions rely on `sclk`, `cs_n` and `sdi` each holding steady for at least three system clocks between changes, so that the two-stage synchronizers present every serial edge as a distinct level change. They also rely on `cs_n` rising only after the last falling `sclk` edge has been seen. The stimulus respects both conditions: it holds each `sclk` phase for four system clocks, changes `sdi` only together with a rising `sclk`, and waits four clocks at both ends of a frame before moving `cs_n`. Random frames mix five cases (matching address, broadcast address, foreign address, corrupted check field and wrong length) over register indices both inside and beyond the bank.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam int FRAME_W = 32;
    localparam int CRC_W   = 12;
    localparam int COVER_W = FRAME_W - CRC_W;
    localparam int REG_AW  = 6;
    localparam int DATA_W  = 8;
    localparam int DEV_AW  = 5;
    localparam int CNT_W   = $clog2(FRAME_W + 2);

    localparam logic [CRC_W-1:0]  CRC_POLY   = 12'h683;
    localparam logic [DEV_AW-1:0] BCAST_ADDR = 5'h1F;

    typedef struct packed {
        logic [DEV_AW-1:0] dev;
        logic              one_way;
        logic [REG_AW-1:0] reg_idx;
        logic [DATA_W-1:0] data;
        logic [CRC_W-1:0]  check;
    } cmd_frame_t;

    // One serial step of the CRC: shift left, fold in the feedback bit.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                  input logic bit_in);
        logic fb;
        fb = cur[CRC_W-1] ^ bit_in;
        return {cur[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & CRC_POLY);
    endfunction
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] rst_val,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stage_q[s] <= rst_val;
                else if (s == 0)
                    stage_q[s] <= d;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
    import spi_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk_s,
    input  logic       cs_n_s,
    input  logic       sdi_s,
    output logic       frame_end,
    output logic       len_ok,
    output logic       crc_ok,
    output cmd_frame_t frame
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_CRC  = CNT_W'(COVER_W);

    logic               sclk_prev, cs_prev;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   bit_cnt;
    logic [CRC_W-1:0]   crc_acc;
    logic               sample;

    assign sample    = sclk_prev & ~sclk_s & ~cs_n_s;
    assign frame_end = ~cs_prev & cs_n_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev <= 1'b0;
            cs_prev   <= 1'b1;
            shreg     <= '0;
            bit_cnt   <= '0;
            crc_acc   <= '0;
        end else begin
            sclk_prev <= sclk_s;
            cs_prev   <= cs_n_s;
            if (cs_n_s) begin
                bit_cnt <= '0;
                crc_acc <= '0;
            end else if (sample) begin
                shreg <= {shreg[FRAME_W-2:0], sdi_s};
                if (bit_cnt != CNT_SAT)
                    bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt < CNT_CRC)
                    crc_acc <= crc_step(crc_acc, sdi_s);
            end
        end
    end

    assign frame  = cmd_frame_t'(shreg);
    assign len_ok = (bit_cnt == CNT_FULL);
    assign crc_ok = (crc_acc == frame.check);
endmodule

// File: rtl/spi_cmd_regbank.sv
module spi_cmd_regbank
    import spi_cmd_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [REG_AW-1:0]          wr_idx,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [NUM_REGS*DATA_W-1:0] regs
);
    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    regs[g*DATA_W +: DATA_W] <= '0;
                else if (wr_en && (wr_idx == REG_AW'(g)))
                    regs[g*DATA_W +: DATA_W] <= wr_data;
            end
        end
    endgenerate
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
    import spi_cmd_pkg::*;
#(
    parameter int                NUM_REGS = 8,
    parameter logic [DEV_AW-1:0] DEV_ADDR = 5'h00
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sclk,
    input  logic                       cs_n,
    input  logic                       sdi,
    output logic [NUM_REGS*DATA_W-1:0] regs_o,
    output logic                       crc_error_o,
    output logic                       one_way_o
);
    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] pins_s;
    logic              frame_end, len_ok, crc_ok, addr_hit, commit, in_bank;
    cmd_frame_t        frame;

    spi_cmd_sync #(.WIDTH(SYNC_W), .STAGES(2)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .rst_val (3'b010),
        .d       ({sclk, cs_n, sdi}),
        .q       (pins_s)
    );

    spi_cmd_shifter shift_i (
        .clk       (clk),
        .rst       (rst),
        .sclk_s    (pins_s[2]),
        .cs_n_s    (pins_s[1]),
        .sdi_s     (pins_s[0]),
        .frame_end (frame_end),
        .len_ok    (len_ok),
        .crc_ok    (crc_ok),
        .frame     (frame)
    );

    assign addr_hit = (frame.dev == DEV_ADDR) || (frame.dev == BCAST_ADDR);
    assign commit   = frame_end & len_ok & crc_ok & addr_hit;
    assign in_bank  = (int'(frame.reg_idx) < NUM_REGS);

    spi_cmd_regbank #(.NUM_REGS(NUM_REGS)) bank_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (commit & in_bank),
        .wr_idx  (frame.reg_idx),
        .wr_data (frame.data),
        .regs    (regs_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_error_o <= 1'b0;
            one_way_o   <= 1'b0;
        end else begin
            if (frame_end && len_ok)
                crc_error_o <= ~crc_ok;
            if (commit)
                one_way_o <= frame.one_way;
        end
    end
endmodule

// File: rtl/spi_cmd_chk.sv
module spi_cmd_chk
    import spi_cmd_pkg::*;
#(
    parameter int                NUM_REGS = 8,
    parameter logic [DEV_AW-1:0] DEV_ADDR = 5'h00
) (
    input logic                       clk,
    input logic                       rst,
    input logic [NUM_REGS*DATA_W-1:0] regs,
    input logic                       crc_error,
    input logic                       one_way,
    input logic                       commit,
    input logic                       frame_end,
    input logic                       len_ok,
    input logic                       crc_ok,
    input logic [DEV_AW-1:0]          dev
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (regs == '0 && !crc_error && !one_way));

    // R2
    regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(regs));

    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(one_way));

    // R4
    err_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(crc_error) |-> $past(frame_end && len_ok && !crc_ok));

    // R4
    err_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(crc_error) |-> $past(frame_end && len_ok && crc_ok));

    // R6
    commit_len_chk: assert property (@(posedge clk) disable iff (rst)
        commit |-> (frame_end && len_ok));

    // R3
    commit_crc_chk: assert property (@(posedge clk) disable iff (rst)
        commit |-> crc_ok);

    // R5
    commit_addr_chk: assert property (@(posedge clk) disable iff (rst)
        commit |-> (dev == DEV_ADDR || dev == BCAST_ADDR));
endmodule

bind spi_cmd_decoder spi_cmd_chk #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .regs      (regs_o),
    .crc_error (crc_error_o),
    .one_way   (one_way_o),
    .commit    (commit),
    .frame_end (frame_end),
    .len_ok    (len_ok),
    .crc_ok    (crc_ok),
    .dev       (frame.dev)
);

// File: tb/spi_cmd_decoder_tb_top.sv
module spi_cmd_decoder_tb_top;
    localparam int NREG = 8;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic sdi = 1'b0;
    logic [NREG*8-1:0] regs_o;
    logic crc_error_o, one_way_o;

    int vectors = 0;
    int misses = 0;
    int cyc = 0;
    logic [7:0] m_regs [NREG];
    logic m_err = 1'b0;
    logic m_mode = 1'b0;

    spi_cmd_decoder #(.NUM_REGS(NREG), .DEV_ADDR(5'h00)) dut_i (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .regs_o(regs_o), .crc_error_o(crc_error_o), .one_way_o(one_way_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            misses++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    // Remainder of (data << 12) modulo the degree-12 generator.
    function automatic logic [11:0] ref_crc(input logic [19:0] data);
        logic [31:0] work;
        work = {data, 12'h000};
        for (int i = 31; i >= 12; i--)
            if (work[i]) work[i -: 13] = work[i -: 13] ^ 13'h1683;
        return work[11:0];
    endfunction

    function automatic logic [31:0] make_frame(input logic [4:0] dev, input logic mode,
                                               input logic [5:0] idx, input logic [7:0] data);
        logic [19:0] hi;
        hi = {dev, mode, idx, data};
        return {hi, ref_crc(hi)};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic send(input logic [31:0] f, input int nbits);
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b1;
            sdi  = (i < 32) ? f[31 - i] : 1'b0;
            wait_clk(HALF);
            sclk = 1'b0;
            wait_clk(HALF);
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(10);
    endtask

    task automatic model(input logic [31:0] f, input int nbits);
        if (nbits != 32) return;
        if (ref_crc(f[31:12]) != f[11:0]) begin
            m_err = 1'b1;
            return;
        end
        m_err = 1'b0;
        if (f[31:27] == 5'h00 || f[31:27] == 5'h1F) begin
            m_mode = f[26];
            if (f[25:20] < 6'(NREG)) m_regs[f[25:20]] = f[19:12];
        end
    endtask

    task automatic compare(input string tag);
        @(negedge clk);
        for (int k = 0; k < NREG; k++) begin
            vectors++;
            if (regs_o[k*8 +: 8] !== m_regs[k]) begin
                misses++;
                $display("FAIL %s reg%0d: actual=%02h expected=%02h", tag, k, regs_o[k*8 +: 8], m_regs[k]);
            end
        end
        vectors++;
        if (crc_error_o !== m_err) begin
            misses++;
            $display("FAIL R4 (%s) crc_error: actual=%b expected=%b", tag, crc_error_o, m_err);
        end
        vectors++;
        if (one_way_o !== m_mode) begin
            misses++;
            $display("FAIL R7 (%s) one_way: actual=%b expected=%b", tag, one_way_o, m_mode);
        end
    endtask

    task automatic run(input logic [31:0] f, input int nbits, input string tag);
        send(f, nbits);
        model(f, nbits);
        compare(tag);
    endtask

    initial begin
        logic [31:0] f;
        for (int k = 0; k < NREG; k++) m_regs[k] = 8'h00;
        void'($urandom(32'h5EED1234));
        wait_clk(5);
        compare("R1");
        rst = 1'b0;
        compare("R1");

        // R2: direct and broadcast writes, bank edges
        run(make_frame(5'h00, 1'b1, 6'd0, 8'hA5), 32, "R2");
        run(make_frame(5'h1F, 1'b0, 6'd7, 8'hFF), 32, "R5");
        // R5: foreign address ignored
        run(make_frame(5'h02, 1'b1, 6'd3, 8'h3C), 32, "R5");
        // R3/R4: corrupted check sets sticky error, no write
        f = make_frame(5'h00, 1'b1, 6'd1, 8'h77) ^ 32'h0000_0001;
        run(f, 32, "R3");
        // R6: short and long frames keep error and registers
        run(make_frame(5'h00, 1'b0, 6'd2, 8'h11), 31, "R6");
        run(make_frame(5'h00, 1'b0, 6'd2, 8'h22), 33, "R6");
        // R4: intact frame to foreign device clears error
        run(make_frame(5'h09, 1'b0, 6'd4, 8'h99), 32, "R4");
        // R8: index past bank, mode still taken
        run(make_frame(5'h00, 1'b1, 6'd8, 8'hEE), 32, "R8");
        run(make_frame(5'h1F, 1'b0, 6'd63, 8'hDD), 32, "R8");
        // R9: sclk toggling with cs_n high
        for (int i = 0; i < 8; i++) begin
            sdi = i[0]; sclk = 1'b1; wait_clk(HALF); sclk = 1'b0; wait_clk(HALF);
        end
        compare("R9");

        for (int n = 0; n < 160; n++) begin
            logic [4:0] dev;
            int kind, nb;
            string tag;
            kind = $urandom_range(0, 9);
            dev  = (kind < 4) ? 5'h00 : (kind < 6) ? 5'h1F : 5'($urandom_range(1, 30));
            f = make_frame(dev, 1'($urandom), 6'($urandom_range(0, 11)), 8'($urandom));
            nb = 32;
            tag = (f[25:20] >= 6'(NREG)) ? "R8" : (kind < 6) ? "R2" : "R5";
            if ($urandom_range(0, 5) == 0) begin
                f[11:0] = f[11:0] ^ 12'($urandom_range(1, 4095));
                tag = "R3";
            end else if ($urandom_range(0, 7) == 0) begin
                nb = $urandom_range(0, 1) ? 30 : 34;
                tag = "R6";
            end
            run(f, nb, tag);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule